// File: doc/BRIEF.md
# Sequenced Market Feed Depacketizer

This block sits behind the transport stripping logic of a market-data receive path. It takes one sequenced feed packet at a time as a stream of 32-bit words and decodes the packet header, which holds a 64-bit sequence number and a 16-bit message count. It sorts each packet into one of three kinds: a heartbeat, an end-of-session marker or a data packet. Every inner message of a data packet comes out on a separate framed output stream, with one message per frame.

The rest of the packet after the header is treated as a big-endian byte stream. Each inner message starts with a 16-bit length and is followed by that many payload bytes. Messages may start and end at any byte position inside a word. The block repacks each payload so that it starts on a word boundary and marks the valid bytes of every output word with a keep mask. For each packet it gives one status pulse carrying the sequence number, the packet kind and an error flag. The error flag is set when the packet ends before its declared messages are complete. Both streams use valid/ready handshakes, so a stalled consumer stops the input without losing data.

Top module: `mfd_depacketizer`

## Requirements
- R1: While reset is held and right after it, `m_valid` and `st_valid` are low and `s_ready` is high.
- R2: The sequence number on `st_seq` is word 0 of the packet in bits 63:32 and word 1 in bits 31:0.
- R3: The message count is bits 31:16 of word 2. Bits 15:0 of word 2 start the message area. Inside a word, byte 0 of the stream is bits 31:24, and each length field is two bytes, high byte first.
- R4: A count of 0 is reported with `st_kind` = 1 (heartbeat). It produces no output words, and every byte after the header is dropped.
- R5: A count of 0xFFFF is reported with `st_kind` = 2 (end of session). It produces no output words.
- R6: Any other count gives `st_kind` = 0 (data), and that many messages are emitted in order. Payload byte i of a message sits in output word i/4, lane i%4, with lane 0 in bits 31:24 and flagged by `m_keep[3]`. Every word before the last of a message has `m_keep` = 4'b1111, and the last word has `m_last` = 1. A message of length zero counts toward the total but emits no word.
- R7: After the last declared message, any bytes up to `s_last` are dropped. The next packet is decoded without a reset.
- R8: `st_valid` pulses exactly once per packet, after the packet's final word has been consumed.
- R9: If `s_last` arrives before the declared messages are complete, `st_err` = 1. A message that was partly emitted is closed with `m_last` on its last received byte. The next packet decodes normally.
- R10: While `m_valid` is high and `m_ready` is low, the output word, mask and last flag hold. No byte is lost or duplicated under any stall pattern.
- R11: A packet that completes normally reports `st_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted |
| s_data | input | 32 | Input packet word |
| s_last | input | 1 | Final word of the packet |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Consumer accepts output word |
| m_data | output | 32 | Output message word |
| m_keep | output | 4 | Byte valid mask, bit 3 for bits 31:24 |
| m_last | output | 1 | Final word of the message |
| st_valid | output | 1 | Per-packet status pulse |
| st_seq | output | 64 | Packet sequence number |
| st_kind | output | 2 | 0 data, 1 heartbeat, 2 end of session |
| st_err | output | 1 | Packet ended before its messages completed |

## Verification
The hardest case to reach from the ports is a packet that is cut short. The cut has to fall inside a length field, or between messages, or partway through a payload whose start was already emitted, and it must happen while the output is stalled. The stimulus builds each random packet as a byte image and then cuts it at a random whole word before the declared end. The stall pattern on `m_ready` changes between phases. Each cut packet is followed directly by an unbroken one, which shows whether the block has resynchronized.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int SEQ_W = 64;
  localparam int CNT_W = 16;
  localparam int LEN_W = 16;
  localparam int HDR_W = SEQ_W + CNT_W;
  localparam int HDR_BYTES = HDR_W / 8;

  typedef enum logic [1:0] {
    PKT_DATA        = 2'd0,
    PKT_HEARTBEAT   = 2'd1,
    PKT_END_SESSION = 2'd2
  } pkt_kind_e;

  typedef enum logic [2:0] {
    FR_HDR,
    FR_LENH,
    FR_LENL,
    FR_PAY,
    FR_DRAIN
  } fr_state_e;
endpackage

// File: rtl/mfd_word_unpacker.sv
module mfd_word_unpacker #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [BYTES*8-1:0] s_data,
  input  logic               s_last,
  output logic               b_valid,
  input  logic               b_ready,
  output logic [7:0]         b_data,
  output logic               b_last
);
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [BYTES*8-1:0] word_q, word_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               full_q, full_d, last_q, last_d;
  logic               at_end, b_fire, load, en;

  always_comb begin
    at_end  = (idx_q == IDX_W'(BYTES - 1));
    b_valid = full_q;
    b_data  = word_q[(BYTES - 1 - int'(idx_q)) * 8 +: 8];
    b_last  = last_q & at_end;
    b_fire  = full_q & b_ready;
    s_ready = !full_q || (b_fire && at_end);
    load    = s_valid & s_ready;
    en      = load | b_fire;
    word_d  = load ? s_data : word_q;
    last_d  = load ? s_last : last_q;
    if (load)
      idx_d = '0;
    else if (b_fire)
      idx_d = idx_q + IDX_W'(1);
    else
      idx_d = idx_q;
    if (load)
      full_d = 1'b1;
    else if (b_fire && at_end)
      full_d = 1'b0;
    else
      full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else if (en) begin
      word_q <= word_d;
      idx_q  <= idx_d;
      full_q <= full_d;
      last_q <= last_d;
    end
  end

  // R10: a held word is not altered while the parser stalls
  a_r10_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !b_ready) |=> (full_q && $stable(word_q) && $stable(idx_q)));
endmodule

// File: rtl/mfd_msg_framer.sv
module mfd_msg_framer
  import mfd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   b_valid,
  output logic                   b_ready,
  input  logic [7:0]             b_data,
  input  logic                   b_last,
  output logic                   p_valid,
  input  logic                   p_ready,
  output logic [7:0]             p_byte,
  output logic                   p_end,
  output logic                   st_valid,
  output logic [SEQ_W-1:0]       st_seq,
  output logic [1:0]             st_kind,
  output logic                   st_err
);
  localparam int HIDX_W = $clog2(HDR_BYTES);

  fr_state_e          state_q, state_d;
  logic [HIDX_W-1:0]  hidx_q, hidx_d;
  logic [HDR_W-1:0]   hdr_q, hdr_d, hdr_full;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_new;
  logic [LEN_W-1:0]   len_q, len_d, len_new;
  pkt_kind_e          kind_q, kind_d, kind_now;
  logic [SEQ_W-1:0]   seq_now;
  logic               b_fire, done, early_end, last_msg;
  logic               stv_q, err_q;
  logic [SEQ_W-1:0]   seq_q;
  pkt_kind_e          skind_q;

  always_comb begin
    b_ready  = (state_q == FR_PAY) ? p_ready : 1'b1;
    p_valid  = (state_q == FR_PAY) & b_valid;
    p_byte   = b_data;
    p_end    = (len_q == LEN_W'(1)) | b_last;
    b_fire   = b_valid & b_ready;
    hdr_full = {hdr_q[HDR_W-9:0], b_data};
    cnt_new  = hdr_full[CNT_W-1:0];
    len_new  = {len_q[LEN_W-1:8], b_data};
    last_msg = (cnt_q == CNT_W'(1));
  end

  always_comb begin
    state_d   = state_q;
    hidx_d    = hidx_q;
    hdr_d     = hdr_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    kind_d    = kind_q;
    kind_now  = kind_q;
    seq_now   = hdr_q[HDR_W-1:CNT_W];
    done      = 1'b0;
    early_end = 1'b0;
    if (b_fire) begin
      case (state_q)
        FR_HDR: begin
          hdr_d    = hdr_full;
          seq_now  = hdr_full[HDR_W-1:CNT_W];
          kind_now = PKT_DATA;
          if (hidx_q == HIDX_W'(HDR_BYTES - 1)) begin
            cnt_d = cnt_new;
            if (cnt_new == '0)
              kind_now = PKT_HEARTBEAT;
            else if (&cnt_new)
              kind_now = PKT_END_SESSION;
            kind_d    = kind_now;
            state_d   = (kind_now == PKT_DATA) ? FR_LENH : FR_DRAIN;
            early_end = (kind_now == PKT_DATA);
          end else begin
            hidx_d    = hidx_q + HIDX_W'(1);
            early_end = 1'b1;
          end
        end
        FR_LENH: begin
          len_d     = {b_data, 8'h00};
          state_d   = FR_LENL;
          early_end = 1'b1;
        end
        FR_LENL: begin
          len_d = len_new;
          if (len_new == '0) begin
            cnt_d     = cnt_q - CNT_W'(1);
            state_d   = last_msg ? FR_DRAIN : FR_LENH;
            early_end = !last_msg;
          end else begin
            state_d   = FR_PAY;
            early_end = 1'b1;
          end
        end
        FR_PAY: begin
          len_d = len_q - LEN_W'(1);
          if (len_q == LEN_W'(1)) begin
            cnt_d     = cnt_q - CNT_W'(1);
            state_d   = last_msg ? FR_DRAIN : FR_LENH;
            early_end = !last_msg;
          end else begin
            early_end = 1'b1;
          end
        end
        default: ;
      endcase
      if (b_last) begin
        done    = 1'b1;
        state_d = FR_HDR;
        hidx_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_HDR;
      hidx_q  <= '0;
      hdr_q   <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      kind_q  <= PKT_DATA;
    end else if (b_fire) begin
      state_q <= state_d;
      hidx_q  <= hidx_d;
      hdr_q   <= hdr_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      kind_q  <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stv_q   <= 1'b0;
      seq_q   <= '0;
      skind_q <= PKT_DATA;
      err_q   <= 1'b0;
    end else begin
      stv_q <= done;
      if (done) begin
        seq_q   <= seq_now;
        skind_q <= kind_now;
        err_q   <= early_end;
      end
    end
  end

  assign st_valid = stv_q;
  assign st_seq   = seq_q;
  assign st_kind  = skind_q;
  assign st_err   = err_q;

  // R8: packets span at least a header, so status never pulses twice in a row
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);
  // R4 R5: sentinel packets never feed payload bytes to the output
  a_r4_r5_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid |-> (kind_q == PKT_DATA));
  // R11: a sentinel packet can only be reported as complete
  a_r11_sentinel_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_kind != PKT_DATA) |-> !st_err);
endmodule

// File: rtl/mfd_byte_packer.sv
module mfd_byte_packer #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_byte,
  input  logic               in_end,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [BYTES*8-1:0] m_data,
  output logic [BYTES-1:0]   m_keep,
  output logic               m_last
);
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [BYTES*8-1:0] acc_q, acc_d, acc_new;
  logic [BYTES-1:0]   kacc_q, kacc_d, kacc_new;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic               fire, emit, acc_en, out_en;
  logic               ov_q, ov_d, ol_q;
  logic [BYTES*8-1:0] od_q;
  logic [BYTES-1:0]   ok_q;

  always_comb begin
    in_ready = !ov_q || m_ready;
    fire     = in_valid & in_ready;
    emit     = fire && (in_end || cnt_q == IDX_W'(BYTES - 1));
    acc_new  = acc_q;
    acc_new[(BYTES - 1 - int'(cnt_q)) * 8 +: 8] = in_byte;
    kacc_new = kacc_q | (BYTES'(1) << (BYTES - 1 - int'(cnt_q)));
    acc_en   = fire;
    acc_d    = emit ? '0 : acc_new;
    kacc_d   = emit ? '0 : kacc_new;
    cnt_d    = emit ? '0 : cnt_q + IDX_W'(1);
    out_en   = emit | m_ready;
    ov_d     = emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      kacc_q <= '0;
      cnt_q  <= '0;
    end else if (acc_en) begin
      acc_q  <= acc_d;
      kacc_q <= kacc_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
    end else if (out_en) begin
      ov_q <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_q <= '0;
      ok_q <= '0;
      ol_q <= 1'b0;
    end else if (emit) begin
      od_q <= acc_new;
      ok_q <= kacc_new;
      ol_q <= in_end;
    end
  end

  assign m_valid = ov_q;
  assign m_data  = od_q;
  assign m_keep  = ok_q;
  assign m_last  = ol_q;

  // R10: a stalled output word keeps its data, mask and framing
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep) && $stable(m_last)));
  // R6: words before the end of a message carry every byte lane
  a_r6_full_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_last) |-> (m_keep == '1));
  // R6: a presented word always carries at least one byte
  a_r6_keep_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_keep != '0));
endmodule

// File: rtl/mfd_depacketizer.sv
module mfd_depacketizer
  import mfd_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int DATA_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [BYTES-1:0]  m_keep,
  output logic              m_last,
  output logic              st_valid,
  output logic [SEQ_W-1:0]  st_seq,
  output logic [1:0]        st_kind,
  output logic              st_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic       b_valid, b_ready, b_last;
  logic [7:0] b_data;
  logic       p_valid, p_ready, p_end;
  logic [7:0] p_byte;

  mfd_word_unpacker #(.BYTES(BYTES)) u_unpack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .s_last  (s_last),
    .b_valid (b_valid),
    .b_ready (b_ready),
    .b_data  (b_data),
    .b_last  (b_last)
  );

  mfd_msg_framer u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .b_data   (b_data),
    .b_last   (b_last),
    .p_valid  (p_valid),
    .p_ready  (p_ready),
    .p_byte   (p_byte),
    .p_end    (p_end),
    .st_valid (st_valid),
    .st_seq   (st_seq),
    .st_kind  (st_kind),
    .st_err   (st_err)
  );

  mfd_byte_packer #(.BYTES(BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (p_valid),
    .in_ready (p_ready),
    .in_byte  (p_byte),
    .in_end   (p_end),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_keep   (m_keep),
    .m_last   (m_last)
  );
endmodule

// File: tb/mfd_depacketizer_test.sv
module mfd_depacketizer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid, s_ready, s_last;
  logic [31:0] s_data;
  logic        m_valid, m_ready, m_last;
  logic [31:0] m_data;
  logic [3:0]  m_keep;
  logic        st_valid, st_err;
  logic [63:0] st_seq;
  logic [1:0]  st_kind;

  always #5 clk = ~clk;

  mfd_depacketizer uut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
    .st_valid(st_valid), .st_seq(st_seq), .st_kind(st_kind), .st_err(st_err)
  );

  int total = 0, bad = 0;
  logic [31:0] exp_data [0:4095];
  logic [3:0]  exp_keep [0:4095];
  logic        exp_last [0:4095];
  logic [63:0] exp_seq  [0:255];
  logic [1:0]  exp_kind [0:255];
  logic        exp_err  [0:255];
  int exp_n = 0, got_n = 0, est_n = 0, gst_n = 0;
  logic [7:0]  pb [0:1023];
  int          msg_len [0:15];
  int          bp_mode = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_msg(int start, int n);
    int k = 0;
    while (k < n) begin
      logic [31:0] d;
      logic [3:0]  kp;
      d = '0;
      kp = '0;
      for (int j = 0; j < 4 && k < n; j++) begin
        d[31-8*j -: 8] = pb[start+k];
        kp[3-j] = 1'b1;
        k++;
      end
      exp_data[exp_n] = d;
      exp_keep[exp_n] = kp;
      exp_last[exp_n] = (k == n);
      exp_n++;
    end
  endtask

  task automatic send_word(logic [31:0] d, bit l);
    bit ok;
    s_data = d;
    s_last = l;
    s_valid = 1'b1;
    do begin
      @(negedge clk);
      ok = s_ready;
      @(posedge clk);
      #1;
    end while (!ok);
    s_valid = 1'b0;
    s_last = 1'b0;
  endtask

  task automatic run_pkt(logic [63:0] seq, logic [15:0] cnt, bit trunc, int pad);
    int nb, end_b, words, sent, lim, pos, avail, kind;
    bit err;
    nb = 0;
    err = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pb[nb] = seq[63-8*i -: 8];
      nb++;
    end
    pb[nb] = cnt[15:8];
    pb[nb+1] = cnt[7:0];
    nb += 2;
    kind = (cnt == 16'h0000) ? 1 : (cnt == 16'hFFFF) ? 2 : 0;
    if (kind == 0) begin
      for (int m = 0; m < int'(cnt); m++) begin
        pb[nb] = 8'(msg_len[m] >> 8);
        pb[nb+1] = 8'(msg_len[m]);
        nb += 2;
        for (int b = 0; b < msg_len[m]; b++) begin
          pb[nb] = 8'($urandom);
          nb++;
        end
      end
    end
    end_b = nb;
    words = (nb + 3) / 4 + pad;
    for (int i = nb; i < words * 4; i++) pb[i] = 8'($urandom);
    sent = words;
    if (trunc && kind == 0 && end_b >= 13)
      sent = int'($urandom_range((end_b - 1) / 4, 3));
    lim = sent * 4;
    pos = 10;
    if (kind == 0) begin
      for (int m = 0; m < int'(cnt); m++) begin
        if (pos + 2 > lim) begin err = 1'b1; break; end
        pos += 2;
        avail = (msg_len[m] < lim - pos) ? msg_len[m] : lim - pos;
        if (avail > 0) push_msg(pos, avail);
        if (avail < msg_len[m]) begin err = 1'b1; break; end
        pos += msg_len[m];
      end
    end
    exp_seq[est_n] = seq;
    exp_kind[est_n] = 2'(kind);
    exp_err[est_n] = err;
    est_n++;
    for (int i = 0; i < sent; i++) begin
      if ($urandom % 4 == 0) begin @(posedge clk); #1; end
      send_word({pb[4*i], pb[4*i+1], pb[4*i+2], pb[4*i+3]}, i == sent - 1);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // consumer readiness, changed only after each rising edge
  initial begin
    m_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      case (bp_mode)
        0: m_ready = 1'b1;
        1: m_ready = ($urandom % 2) == 0;
        default: m_ready = ($urandom % 5) == 0;
      endcase
    end
  end

  // output and status monitor, sampling mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (m_valid && m_ready) begin
        if (got_n >= exp_n) begin
          chk(1'b0, "R7", "unexpected output word", 64'(m_data), 64'd0);
        end else begin
          logic [31:0] mk;
          mk = {{8{m_keep[3]}}, {8{m_keep[2]}}, {8{m_keep[1]}}, {8{m_keep[0]}}};
          chk((m_data & mk) == (exp_data[got_n] & mk) && m_keep == exp_keep[got_n] &&
              m_last == exp_last[got_n], "R3 R6 R10", "output word",
              64'({m_keep, m_last, m_data}),
              64'({exp_keep[got_n], exp_last[got_n], exp_data[got_n]}));
        end
        got_n++;
      end
      if (st_valid) begin
        if (gst_n >= est_n) begin
          chk(1'b0, "R8", "unexpected status pulse", st_seq, 64'd0);
        end else begin
          chk(st_seq == exp_seq[gst_n], "R2", "sequence number", st_seq, exp_seq[gst_n]);
          chk(st_kind == exp_kind[gst_n], "R4 R5", "packet kind", 64'(st_kind), 64'(exp_kind[gst_n]));
          chk(st_err == exp_err[gst_n], "R9 R11", "error flag", 64'(st_err), 64'(exp_err[gst_n]));
        end
        gst_n++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", got_n, exp_n);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd61017));
    s_valid = 1'b0;
    s_data = '0;
    s_last = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(s_ready == 1'b1 && m_valid == 1'b0 && st_valid == 1'b0, "R1", "reset outputs",
        64'({s_ready, m_valid, st_valid}), 64'(3'b100));
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(s_ready == 1'b1 && m_valid == 1'b0 && st_valid == 1'b0, "R1", "after reset",
        64'({s_ready, m_valid, st_valid}), 64'(3'b100));
    @(posedge clk);
    #1;

    // R4 heartbeat, R5 end of session with trailing pad
    run_pkt(64'h0123_4567_89AB_CDEF, 16'h0000, 1'b0, 1);
    run_pkt(64'hFEDC_BA98_7654_3210, 16'hFFFF, 1'b0, 1);
    // R6 zero-length single message, then exact-fit and lane-crossing messages
    msg_len[0] = 0;
    run_pkt(64'd1, 16'd1, 1'b0, 0);
    msg_len[0] = 2;
    run_pkt(64'd2, 16'd1, 1'b0, 0);
    msg_len[0] = 1; msg_len[1] = 5; msg_len[2] = 9;
    run_pkt(64'd3, 16'd3, 1'b0, 2);
    // R9 truncated under stalls, then R7 resync on a clean packet
    bp_mode = 2;
    for (int m = 0; m < 4; m++) msg_len[m] = 8;
    run_pkt(64'd4, 16'd4, 1'b1, 0);
    msg_len[0] = 3; msg_len[1] = 0; msg_len[2] = 6;
    run_pkt(64'd5, 16'd3, 1'b0, 0);
    run_pkt(64'd6, 16'd0, 1'b0, 0);

    for (int p = 0; p < 48; p++) begin
      int c, r;
      bp_mode = (p / 8) % 3;
      r = int'($urandom % 20);
      if (r == 0) begin
        run_pkt(rnd64(), 16'h0000, 1'b0, int'($urandom % 3));
      end else if (r == 1) begin
        run_pkt(rnd64(), 16'hFFFF, 1'b0, int'($urandom % 3));
      end else begin
        c = int'($urandom_range(6, 1));
        for (int m = 0; m < c; m++) msg_len[m] = int'($urandom_range(13, 0));
        run_pkt(rnd64(), 16'(c), ($urandom % 7) == 0, int'($urandom % 3));
      end
    end

    bp_mode = 1;
    cyc = 0;
    while ((got_n < exp_n || gst_n < est_n) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    repeat (30) @(posedge clk);
    #1;
    chk(got_n == exp_n, "R7 R10", "output word count", 64'(got_n), 64'(exp_n));
    chk(gst_n == est_n, "R8", "status pulse count", 64'(gst_n), 64'(est_n));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule